// File: doc/BRIEF.md
# Integer ALU with NZCV Flag Generation

This block is the combinational arithmetic and logic unit of a small pipelined processor core. It takes two operands, a 4-bit command code, and the current carry and overflow flags. It returns a result word and a fresh set of negative, zero, carry and overflow flags. A single shared adder serves every arithmetic command. Subtraction feeds it the inverted second operand, and subtract-with-carry removes one more unit when the carry flag is clear.

Compare and test use the same codes as subtract and AND; the caller discards the result. Load/store address generation uses the add code. Whether the flags are written back is decided by the status register outside this block. For commands that have no defined carry or overflow, the incoming flag values pass through unchanged, so the status register can commit all four flags without special cases.

Top module: `alu_nzcv`

## Requirements
- R1: Command 4'b0001 outputs op_b unchanged; flag_c equals carry_in and flag_v equals ovf_in.
- R2: Command 4'b1001 outputs the bitwise inverse of op_b; flag_c and flag_v pass through from carry_in and ovf_in.
- R3: Command 4'b0010 outputs op_a + op_b modulo 2^WIDTH. flag_c is the carry out of the top bit. flag_v is set when the signed sum falls outside the signed range.
- R4: Command 4'b0011 outputs op_a + op_b + carry_in, with carry and signed overflow defined as in R3.
- R5: Command 4'b0100 outputs op_a - op_b modulo 2^WIDTH. flag_c is 1 exactly when op_a >= op_b unsigned, meaning no borrow. flag_v is set when the signed difference falls outside the signed range.
- R6: Command 4'b0101 outputs op_a - op_b - (1 - carry_in). flag_c is 1 exactly when op_a >= op_b + (1 - carry_in) unsigned. flag_v follows the signed range of the full difference.
- R7: Commands 4'b0110, 4'b0111 and 4'b1000 output bitwise AND, OR and XOR of the operands, with flag_c and flag_v passed through.
- R8: Codes 4'b0000 and 4'b1010 to 4'b1111 output zero, with flag_c and flag_v passed through.
- R9: For every command, flag_n equals the top result bit and flag_z is 1 exactly when every result bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend for subtraction) |
| op_b | input | WIDTH | Second operand |
| cmd | input | 4 | Command code |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| result | output | WIDTH | Computed result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow for subtraction) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bound checker evaluates every input change. It covers the move pass-through, the 33-bit sum of plain addition, the difference and no-borrow carry of plain subtraction, the AND command, and the zeroed result of unused codes. Carry-in handling for the two with-carry commands, signed overflow on every arithmetic command, and the N/Z flags across all codes can only be shown by the bench. It runs an exhaustive sweep of a 4-bit build and compares every output with values computed by integer arithmetic.

// File: rtl/alu_nzcv.sv
module alu_nzcv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       cmd,
  input  logic             carry_in,
  input  logic             ovf_in,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] CMD_MOV = 4'b0001;
  localparam logic [3:0] CMD_MVN = 4'b1001;
  localparam logic [3:0] CMD_ADD = 4'b0010;
  localparam logic [3:0] CMD_ADC = 4'b0011;
  localparam logic [3:0] CMD_SUB = 4'b0100;
  localparam logic [3:0] CMD_SBC = 4'b0101;
  localparam logic [3:0] CMD_AND = 4'b0110;
  localparam logic [3:0] CMD_ORR = 4'b0111;
  localparam logic [3:0] CMD_EOR = 4'b1000;

  logic             is_sub;
  logic             is_arith;
  logic             use_cin;
  logic [WIDTH-1:0] add_b;
  logic             add_ci;
  logic [WIDTH:0]   sum;
  logic             add_v;

  assign is_sub   = (cmd == CMD_SUB) || (cmd == CMD_SBC);
  assign is_arith = is_sub || (cmd == CMD_ADD) || (cmd == CMD_ADC);
  assign use_cin  = (cmd == CMD_ADC) || (cmd == CMD_SBC);

  // subtraction: a + ~b + 1, and the borrowing form a + ~b + c
  assign add_b  = is_sub ? ~op_b : op_b;
  assign add_ci = use_cin ? carry_in : is_sub;
  assign sum    = {1'b0, op_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_ci};
  assign add_v  = (op_a[MSB] == add_b[MSB]) && (sum[MSB] != op_a[MSB]);

  always_comb begin
    unique case (cmd)
      CMD_MOV: result = op_b;
      CMD_MVN: result = ~op_b;
      CMD_ADD,
      CMD_ADC,
      CMD_SUB,
      CMD_SBC: result = sum[MSB:0];
      CMD_AND: result = op_a & op_b;
      CMD_ORR: result = op_a | op_b;
      CMD_EOR: result = op_a ^ op_b;
      default: result = '0;
    endcase
  end

  assign flag_n = result[MSB];
  assign flag_z = ~|result;
  assign flag_c = is_arith ? sum[WIDTH] : carry_in;
  assign flag_v = is_arith ? add_v : ovf_in;
endmodule

module alu_nzcv_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       cmd,
  input logic             carry_in,
  input logic             ovf_in,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic [WIDTH:0] wide_sum;
  assign wide_sum = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    if (cmd == 4'b0001)
      a_r1_move_pass: assert (result == op_b && flag_c == carry_in && flag_v == ovf_in);
    if (cmd == 4'b0010)
      a_r3_add_carry: assert ({flag_c, result} == wide_sum);
    if (cmd == 4'b0100)
      a_r5_sub_noborrow: assert (result == op_a - op_b && flag_c == (op_a >= op_b));
    if (cmd == 4'b0110)
      a_r7_and_bits: assert (result == (op_a & op_b) && flag_c == carry_in);
    if (cmd == 4'b0000 || cmd >= 4'b1010)
      a_r8_unused_zero: assert (result == '0 && flag_z && !flag_n && flag_v == ovf_in);
  end
endmodule

bind alu_nzcv alu_nzcv_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .cmd(cmd), .carry_in(carry_in), .ovf_in(ovf_in),
  .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu_nzcv_tb.sv
module alu_nzcv_tb;
  localparam int W    = 4;
  localparam int M    = 1 << W;
  localparam int HALF = M / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   cmd = '0;
  logic         carry_in = 1'b0;
  logic         ovf_in = 1'b0;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_nzcv #(.WIDTH(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .cmd(cmd), .carry_in(carry_in), .ovf_in(ovf_in),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic string req_of(int c);
    case (c)
      1: return "R1";
      9: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6, 7, 8: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int sgn(int u);
    return (u >= HALF) ? u - M : u;
  endfunction

  task automatic check_one(int c, int ua, int ub, int ci, int vi);
    int er, ec, ev, s, sv;
    ec = ci;
    ev = vi;
    case (c)
      1: er = ub;
      9: er = (M - 1) - ub;
      2, 3: begin
        s  = ua + ub + ((c == 3) ? ci : 0);
        sv = sgn(ua) + sgn(ub) + ((c == 3) ? ci : 0);
        er = s % M;
        ec = (s >= M) ? 1 : 0;
        ev = (sv >= HALF || sv < -HALF) ? 1 : 0;
      end
      4, 5: begin
        s  = ua - ub - ((c == 5) ? 1 - ci : 0);
        sv = sgn(ua) - sgn(ub) - ((c == 5) ? 1 - ci : 0);
        er = (s + 2 * M) % M;
        ec = (s >= 0) ? 1 : 0;
        ev = (sv >= HALF || sv < -HALF) ? 1 : 0;
      end
      6: er = ua & ub;
      7: er = ua | ub;
      8: er = ua ^ ub;
      default: er = 0;
    endcase
    checks++;
    if (int'(result) != er || int'(flag_c) != ec || int'(flag_v) != ev) begin
      errors++;
      if (errors < 30)
        $display("FAIL %s cmd=%0d a=%0d b=%0d ci=%0d vi=%0d: res/c/v actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 req_of(c), c, ua, ub, ci, vi, result, flag_c, flag_v, er, ec, ev);
    end
    checks++;
    if (int'(flag_n) != ((er >= HALF) ? 1 : 0) || int'(flag_z) != ((er == 0) ? 1 : 0)) begin
      errors++;
      if (errors < 30)
        $display("FAIL R9 cmd=%0d a=%0d b=%0d: n/z actual %0d/%0d expected %0d/%0d",
                 c, ua, ub, flag_n, flag_z, (er >= HALF) ? 1 : 0, (er == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // sweep covers R1 R2 R3 R4 R5 R6 R7 R8 R9 exhaustively at W=4
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            cmd      = 4'(c);
            op_a     = W'(a);
            op_b     = W'(b);
            carry_in = f[0];
            ovf_in   = f[1];
            #1;
            check_one(c, a, b, int'(f[0]), int'(f[1]));
          end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule